// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers level-sensitive interrupt requests from a large set of peripheral inputs and a few request bits that software sets and clears. Every real source gets a 4-bit priority. A pipelined scan picks the pending source with the highest priority. The block raises one request line toward the processor, together with a 9-bit vector naming that source, only when the winning priority is strictly above the current running priority.

Accepting a request saves the old current priority on a hardware stack (LIFO) and makes the accepted source's priority current. Handlers of lower or equal priority are therefore masked until software writes end-of-interrupt, which restores the saved level. Software may also write the current priority itself to hold a ceiling while it touches a shared resource. The software request bits let one handler pass deferred work to a lower-priority handler, or let processors signal each other.

A control bit selects one of two handshakes. In software-vector mode the handler reads an acknowledge register, which returns the vector and performs the save. In hardware-vector mode the vector travels beside the request and a separate acknowledge pin performs the save.

Top module: `prio_intc`

## Requirements
- R1: After reset, irq_req is low, the current priority is 0, the LIFO is empty, the mode bit (CTRL 0x000 bit 0) is 0, all software request bits are 0 and the error flag (STATUS 0x005 bit 0) is 0.
- R2: Slot numbering is as follows. Software request n occupies slot n, for n from 0 to N_SW-1. Peripheral input i occupies slot N_SW+i. The N_RSVD slots above these never request. irq_vec carries the 9-bit slot number of the winner.
- R3: The winner is the pending source with the highest nonzero priority. On a tie, the lowest slot number wins. A source with priority 0 never requests.
- R4: irq_req is high only when the winner's priority is strictly greater than the current priority.
- R5: If a peripheral input is high before rising edge 1, and the controller is idle with the current priority below that input's priority, then irq_req is high after rising edge 3 and not before.
- R6: In software-vector mode, a read of ACK (0x002) while irq_req is high returns bit 16 set and the vector in bits 8:0. The same read pushes the current priority, loads the winner's priority as the new current priority, and lowers irq_req at that edge. A read while irq_req is low returns 0 and changes nothing.
- R7: With CTRL bit 0 set, a cycle in which both irq_ack and irq_req are high performs the push and load, and an ACK read does not. With CTRL bit 0 clear, irq_ack has no effect.
- R8: A write to EOI (0x003) pops the LIFO into the current priority. It never clears any request source.
- R9: A write to CURPRI (0x001, bits 3:0) sets the current priority directly. Sources at or below that level are masked.
- R10: A write to SWREQ (0x004) sets each request bit n whose bit n in the written data is 1, and clears each bit n whose bit N_SW+n is 1. Clear wins when both are 1. A read of SWREQ returns the request bits.
- R11: The LIFO holds 15 entries. A push when full or a pop when empty sets the sticky error flag and leaves the stored entries unchanged. A push when full still loads the new current priority, and a pop when empty leaves the current priority unchanged. Writing 1 to STATUS bit 0 clears the flag.
- R12: Priority registers sit at 0x200 plus the slot number, in bits 3:0, and read back what was written. Accesses to reserved slots are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| periph_irq | input | N_PERIPH (279) | Level requests from peripherals |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W (10) | Register address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after the read strobe |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_vec | output | VEC_W (9) | Slot number of the pending request |
| irq_ack | input | 1 | Acknowledge pin, used in hardware-vector mode |

## Verification
The bench goes after the tie between equal priorities, where a design that scans in the wrong direction reports the higher slot. It also checks that a source equal to the current level gets no request, which a design that compares with "greater or equal" would get wrong. Exact three-edge latency is checked, and an extra or missing pipeline stage would show up there. The acknowledge pin is pulsed in the wrong mode, and a design that ignores the mode would nest anyway. The LIFO is filled with distinct saved levels and then pushed once more, so an overflow that overwrote the top entry would restore the wrong level on the next end-of-interrupt. End-of-interrupt is written while the source stays active, to catch a design that clears the source on end-of-interrupt.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int PRIO_W = 4;
  typedef logic [PRIO_W-1:0] prio_t;

  // register offsets
  localparam int A_CTRL  = 'h000;
  localparam int A_CUR   = 'h001;
  localparam int A_ACK   = 'h002;
  localparam int A_EOI   = 'h003;
  localparam int A_SWREQ = 'h004;
  localparam int A_STAT  = 'h005;
  localparam int A_PRIO  = 'h200;

  localparam int ACK_VALID_BIT = 16;
endpackage

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
  import intc_pkg::*;
#(
  parameter int N_SRC = 287,
  parameter int IDX_W = 9
) (
  input  logic [N_SRC-1:0]             pend,
  input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
  output prio_t                        best_prio,
  output logic [IDX_W-1:0]             best_idx
);
  // scan from the top slot down; ">=" lets a lower slot take a tie
  always_comb begin
    best_prio = '0;
    best_idx  = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && (prio[i] != '0) && (prio[i] >= best_prio)) begin
        best_prio = prio[i];
        best_idx  = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intc_lifo.sv
`timescale 1ns/1ps
module intc_lifo
  import intc_pkg::*;
#(
  parameter int DEPTH = 15
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  logic  pop,
  input  prio_t din,
  input  logic  err_clr,
  output prio_t top,
  output logic  empty,
  output logic  err
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  prio_t            mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_m1;
  logic             full, do_push, do_pop, err_q;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !push && !empty;
  assign cnt_m1  = cnt_q - CNT_W'(1);
  assign top     = empty ? '0 : mem[cnt_m1[IDX_W-1:0]];
  assign err     = err_q;

  // storage without reset so it can map to RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[cnt_q[IDX_W-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (do_push) cnt_q <= cnt_q + CNT_W'(1);
    else if (do_pop)  cnt_q <= cnt_m1;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else if ((push && full) || (pop && !push && empty)) err_q <= 1'b1;
    else if (err_clr) err_q <= 1'b0;
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(DEPTH));
  assert_full_push_keeps_R11: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> cnt_q == $past(cnt_q));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_PERIPH   = 279,
  parameter int N_SW       = 8,
  parameter int N_RSVD     = 199,
  parameter int LIFO_DEPTH = 15,
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 32,
  parameter int N_REAL     = N_SW + N_PERIPH,
  parameter int VEC_W      = $clog2(N_REAL + N_RSVD)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_PERIPH-1:0] periph_irq,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_req,
  output logic [VEC_W-1:0]    irq_vec,
  input  logic                irq_ack
);
  logic [N_PERIPH-1:0]             src_q;
  logic [N_SW-1:0]                 sw_q;
  logic                            hven_q, req_q;
  prio_t                           cur_q, win_prio_d, win_prio_q, req_prio_q, lifo_top;
  logic [VEC_W-1:0]                win_idx_d, win_idx_q, vec_q;
  logic [N_REAL-1:0][PRIO_W-1:0]   prio_all;
  logic [N_REAL-1:0]               pend;
  logic [ADDR_W-1:0]               prio_off;
  logic [DATA_W-1:0]               rd_mux, rdata_q;
  logic wr_ctrl, wr_cur, wr_sw, wr_stat, eoi, prio_hit, ack_rd, take, lifo_empty, lifo_err;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:2*N_SW];

  // ---------------- register decode
  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign wr_cur   = bus_wr && (bus_addr == ADDR_W'(A_CUR));
  assign wr_sw    = bus_wr && (bus_addr == ADDR_W'(A_SWREQ));
  assign wr_stat  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
  assign eoi      = bus_wr && (bus_addr == ADDR_W'(A_EOI));
  assign prio_hit = (bus_addr >= ADDR_W'(A_PRIO)) && (bus_addr < ADDR_W'(A_PRIO + N_REAL));
  assign prio_off = bus_addr - ADDR_W'(A_PRIO);
  assign ack_rd   = bus_rd && (bus_addr == ADDR_W'(A_ACK)) && !hven_q;
  assign take     = req_q && (hven_q ? irq_ack : ack_rd);

  // ---------------- per-slot priority registers
  for (genvar s = 0; s < N_REAL; s++) begin : g_prio
    prio_t p_q;
    always_ff @(posedge clk) begin
      if (rst) p_q <= '0;
      else if (bus_wr && prio_hit && (prio_off == ADDR_W'(s))) p_q <= bus_wdata[PRIO_W-1:0];
    end
    assign prio_all[s] = p_q;
  end

  // ---------------- request capture (stage 1)
  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      sw_q   <= '0;
      hven_q <= 1'b0;
    end else begin
      src_q <= periph_irq;
      if (wr_sw)   sw_q   <= (sw_q | bus_wdata[N_SW-1:0]) & ~bus_wdata[2*N_SW-1:N_SW];
      if (wr_ctrl) hven_q <= bus_wdata[0];
    end
  end

  assign pend = {src_q, sw_q};

  // ---------------- selection (stage 2)
  intc_arbiter #(.N_SRC(N_REAL), .IDX_W(VEC_W)) u_arb (
    .pend(pend), .prio(prio_all), .best_prio(win_prio_d), .best_idx(win_idx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_prio_q <= '0;
      win_idx_q  <= '0;
    end else begin
      win_prio_q <= win_prio_d;
      win_idx_q  <= win_idx_d;
    end
  end

  // ---------------- compare and request (stage 3)
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q      <= 1'b0;
      req_prio_q <= '0;
      vec_q      <= '0;
    end else begin
      req_q      <= take ? 1'b0 : (win_prio_q > cur_q);
      req_prio_q <= win_prio_q;
      vec_q      <= win_idx_q;
    end
  end

  // ---------------- current priority and saved levels
  intc_lifo #(.DEPTH(LIFO_DEPTH)) u_lifo (
    .clk(clk), .rst(rst), .push(take), .pop(eoi), .din(cur_q),
    .err_clr(wr_stat && bus_wdata[0]), .top(lifo_top), .empty(lifo_empty), .err(lifo_err)
  );

  always_ff @(posedge clk) begin
    if (rst)                      cur_q <= '0;
    else if (take)                cur_q <= req_prio_q;
    else if (eoi && !lifo_empty)  cur_q <= lifo_top;
    else if (wr_cur)              cur_q <= bus_wdata[PRIO_W-1:0];
  end

  // ---------------- read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(A_CTRL))       rd_mux[0] = hven_q;
    else if (bus_addr == ADDR_W'(A_CUR))   rd_mux[PRIO_W-1:0] = cur_q;
    else if (bus_addr == ADDR_W'(A_ACK)) begin
      if (req_q) begin
        rd_mux[ACK_VALID_BIT] = 1'b1;
        rd_mux[VEC_W-1:0]     = vec_q;
      end
    end
    else if (bus_addr == ADDR_W'(A_SWREQ)) rd_mux[N_SW-1:0] = sw_q;
    else if (bus_addr == ADDR_W'(A_STAT))  rd_mux[0] = lifo_err;
    else if (prio_hit)                     rd_mux[PRIO_W-1:0] = prio_all[prio_off];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;
  assign irq_req   = req_q;
  assign irq_vec   = vec_q;

  // ---------------- assertions
  assert_vec_real_R2: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> irq_vec < VEC_W'(N_REAL));
  assert_win_pending_R3: assert property (@(posedge clk) disable iff (rst)
    (win_prio_d != '0) |-> pend[win_idx_d]);
  assert_req_above_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_q) && !$past(bus_wr)) |-> req_prio_q > cur_q);
  assert_ack_loads_R6: assert property (@(posedge clk) disable iff (rst)
    take |=> (cur_q == $past(req_prio_q)) && !req_q);
  assert_pin_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!hven_q && irq_ack && !bus_wr && !bus_rd) |=> cur_q == $past(cur_q));
endmodule

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  localparam int NP = 279, NS = 8, NR = 199, NREAL = NP + NS;
  localparam int VALID = 65536;

  logic        clk = 1'b0, rst = 1'b1;
  logic [NP-1:0] periph_irq = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, irq_ack = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_req;
  logic [8:0]  irq_vec;

  int nchk = 0, nerr = 0;
  int m_prio [NREAL];
  logic [NP-1:0] m_per;
  logic [NS-1:0] m_sw;

  prio_intc i_prio_intc (
    .clk(clk), .rst(rst), .periph_irq(periph_irq), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack)
  );

  always #4 clk = ~clk;

  task automatic chk(input string r, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = 32'(d);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    bus_rd = 1'b1; bus_addr = 10'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = int'(bus_rdata);
  endtask

  function automatic void model(output int bp, output int bi);
    bp = 0; bi = 0;
    for (int i = 0; i < NREAL; i++) begin
      logic p;
      p = (i < NS) ? m_sw[i] : m_per[i-NS];
      if (p && m_prio[i] > bp) begin bp = m_prio[i]; bi = i; end
    end
  endfunction

  task automatic do_reset();
    rst = 1'b1; periph_irq = '0;
    tick(4);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int d;
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();

    // R1 reset state
    chk("R1 irq_req", int'(irq_req), 0);
    rd('h000, d); chk("R1 ctrl", d, 0);
    rd('h001, d); chk("R1 cur", d, 0);
    rd('h004, d); chk("R1 swreq", d, 0);
    rd('h005, d); chk("R1 status", d, 0);

    // R11 underflow at empty
    wr('h003, 0);
    rd('h005, d); chk("R11 underflow err", d, 1);
    rd('h001, d); chk("R11 underflow cur", d, 0);
    wr('h005, 1);
    rd('h005, d); chk("R11 err clear", d, 0);

    // R12 priority registers
    wr('h200 + NREAL + 3, 7);
    rd('h200 + NREAL + 3, d); chk("R12 reserved reads 0", d, 0);
    wr('h200 + 20, 9);
    rd('h200 + 20, d); chk("R12 readback", d, 9);
    wr('h200 + 20, 0);

    // R5 latency, R2 vector numbering
    wr('h200 + NS + 5, 6);
    periph_irq[5] = 1'b1;
    for (int n = 1; n <= 3; n++) begin
      @(negedge clk);
      chk("R5 latency", int'(irq_req), (n == 3) ? 1 : 0);
    end
    chk("R2 vector", int'(irq_vec), NS + 5);

    // R3 tie goes to lower slot; priority 0 ignored
    periph_irq[10] = 1'b1;
    wr('h200 + NS + 2, 6);
    periph_irq[2] = 1'b1;
    tick(4);
    chk("R3 tie lowest slot", int'(irq_vec), NS + 2);
    wr('h200 + NS + 2, 0);
    tick(4);
    chk("R3 prio0 skipped", int'(irq_vec), NS + 5);
    periph_irq[2] = 1'b0; periph_irq[10] = 1'b0;

    // R4 strict comparison, R9 ceiling
    wr('h001, 6); tick(3);
    chk("R4 equal masks", int'(irq_req), 0);
    wr('h001, 10); tick(3);
    chk("R9 ceiling masks", int'(irq_req), 0);
    wr('h001, 5); tick(3);
    chk("R4 above requests", int'(irq_req), 1);
    wr('h001, 0); tick(3);

    // R7 pin ignored in software mode
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd('h001, d); chk("R7 pin ignored cur", d, 0);
    chk("R7 pin ignored req", int'(irq_req), 1);

    // R6 acknowledge read
    rd('h002, d); chk("R6 ack data", d, VALID + NS + 5);
    chk("R6 req drops", int'(irq_req), 0);
    rd('h001, d); chk("R6 cur loaded", d, 6);

    // preemption, R8 end-of-interrupt
    wr('h200 + NS + 7, 9);
    periph_irq[7] = 1'b1;
    tick(4);
    chk("R4 preempt req", int'(irq_req), 1);
    chk("R4 preempt vec", int'(irq_vec), NS + 7);
    rd('h002, d);
    rd('h001, d); chk("R6 nested cur", d, 9);
    wr('h003, 0);
    rd('h001, d); chk("R8 pop restores", d, 6);
    tick(3);
    chk("R8 source not cleared", int'(irq_req), 1);
    periph_irq[7] = 1'b0;
    wr('h003, 0);
    rd('h001, d); chk("R8 pop to base", d, 0);

    // R6 read without request
    wr('h001, 15); tick(3);
    rd('h002, d); chk("R6 idle ack data", d, 0);
    rd('h001, d); chk("R6 idle ack cur", d, 15);
    wr('h001, 0);
    periph_irq = '0;
    tick(4);

    // R10 software requests
    wr('h200 + 3, 12);
    wr('h004, 'h0008); tick(3);
    chk("R10 sw req", int'(irq_req), 1);
    chk("R10 sw vec", int'(irq_vec), 3);
    rd('h004, d); chk("R10 readback", d, 8);
    wr('h004, 'h0808);
    rd('h004, d); chk("R10 clear wins", d, 0);
    tick(3);
    chk("R10 cleared no req", int'(irq_req), 0);
    wr('h200 + 1, 12);
    wr('h004, 'h000A); tick(4);
    chk("R3 sw tie", int'(irq_vec), 1);
    wr('h004, 'h0200); tick(4);

    // R7 hardware-vector mode
    wr('h000, 1);
    rd('h000, d); chk("R7 ctrl", d, 1);
    chk("R7 hw req vec", int'(irq_vec), 3);
    rd('h002, d); chk("R7 ack data", d, VALID + 3);
    rd('h001, d); chk("R7 read no push", d, 0);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    chk("R7 pin drops req", int'(irq_req), 0);
    rd('h001, d); chk("R7 pin loads cur", d, 12);
    wr('h003, 0);
    rd('h001, d); chk("R7 hw pop", d, 0);
    wr('h004, 'h0800);
    wr('h000, 0);
    tick(4);

    // R11 overflow with distinct saved levels
    wr('h200 + 0, 15);
    wr('h004, 'h0001);
    for (int j = 0; j < 15; j++) begin
      wr('h001, j); tick(3);
      rd('h002, d);
    end
    rd('h005, d); chk("R11 full no err", d, 0);
    wr('h001, 3); tick(3);
    rd('h002, d); chk("R11 ack on full", d, VALID + 0);
    rd('h005, d); chk("R11 overflow err", d, 1);
    rd('h001, d); chk("R11 overflow cur", d, 15);
    wr('h004, 'h0100);
    wr('h005, 1);
    wr('h003, 0);
    rd('h001, d); chk("R11 top intact", d, 14);
    for (int j = 0; j < 14; j++) wr('h003, 0);
    rd('h001, d); chk("R11 bottom", d, 0);
    rd('h005, d); chk("R11 no err", d, 0);
    wr('h003, 0);
    rd('h005, d); chk("R11 underflow after drain", d, 1);
    rd('h001, d); chk("R11 cur kept", d, 0);

    // random phase against the model
    do_reset();
    for (int i = 0; i < NREAL; i++) m_prio[i] = 0;
    m_sw = '0;
    for (int it = 0; it < 40; it++) begin
      int bp, bi, c, s;
      for (int k = 0; k < 6; k++) begin
        int slot, p;
        slot = int'($urandom % NREAL);
        p = int'($urandom % 16);
        wr('h200 + slot, p);
        m_prio[slot] = p;
      end
      for (int i = 0; i < NP; i++) m_per[i] = (($urandom % 16) == 0);
      periph_irq = m_per;
      s = int'($urandom % 256);
      wr('h004, ((~s & 255) << 8) | s);
      m_sw = 8'(s);
      c = int'($urandom % 16);
      wr('h001, c);
      tick(4);
      model(bp, bi);
      chk("R4 random req", int'(irq_req), (bp > c) ? 1 : 0);
      if (bp > c) chk("R3 random vec", int'(irq_vec), bi);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule